// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside the fetch stage and guesses where the next fetch should go. It keeps a direct-mapped table of 128 entries. Each entry holds a valid bit, an address tag, a branch target and a two-bit saturating history counter. On every cycle the fetch address is looked up. If it hits an entry whose counter leans taken, the stored target is offered as the next fetch address. In every other case the block offers the sequential address, which is the fetch address plus 4.

Later in the pipeline a branch resolves and is reported on the update port with its actual direction and target. In the same cycle the block reads the entry for that branch through a second read port. It raises a mispredict flag when the earlier guess would have been wrong, and at the clock edge it writes the trained entry back. An entry is created only for a branch that misses and turns out taken, and a new entry always starts in the strongly-not-taken state. A single enable input forces every prediction to be sequential. Training goes on while the enable is low.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: each lookup gives pred_hit_o=0, pred_taken_o=0 and pred_pc_o = fetch_pc_i + 4.
- R2: The table index is fetch_pc_i[8:2] and the tag is fetch_pc_i[31:9]. History is encoded as 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. A hit whose history has bit 1 set, with en_i high, gives pred_taken_o=1 and pred_pc_o equal to the stored target.
- R3: A hit whose history has bit 1 clear gives pred_taken_o=0 and pred_pc_o = fetch_pc_i + 4.
- R4: An update with upd_taken_i=1 that misses writes its slot as follows: valid, tag from upd_pc_i, target upd_target_i, history 00. Any entry already in that slot is overwritten.
- R5: An update with upd_taken_i=0 that misses changes no entry.
- R6: An update that hits moves the history one step toward 11 if taken, or one step toward 00 if not taken, and never wraps. A taken hit also replaces the stored target with upd_target_i.
- R7: With en_i low, pred_taken_o=0 and pred_pc_o = fetch_pc_i + 4. Updates still train the table.
- R8: mispredict_o is combinational and is valid while upd_valid_i is high. It is 1 when the predicted direction (en_i and hit and history bit 1) differs from upd_taken_i, or when both are taken and the stored target differs from upd_target_i. It is 0 when upd_valid_i is low.
- R9: An update takes effect at the clock edge. A lookup in the same cycle sees the entry's earlier contents, and lookups from the next cycle see the new contents.
- R10: A fetch address with the same index as an entry but a different tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Prediction enable |
| fetch_pc_i | input | 32 | Fetch address to look up |
| pred_hit_o | output | 1 | Lookup found a matching valid entry |
| pred_taken_o | output | 1 | Prediction is taken |
| pred_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |
| mispredict_o | output | 1 | The reported branch was mispredicted |

## Verification
The assertions check the following on every cycle:
- a taken prediction needs both the enable and a hit, and any other prediction is the sequential address;
- a taken miss writes a strongly-not-taken entry with the reported target, and a not-taken miss leaves the valid bits alone;
- the counter saturates at both ends;
- the mispredict flag stays low when no update is reported.

Only the bench scenarios can show the following, because each depends on the exact contents of an entry over several updates:
- the full training walk through all four history states;
- target replacement;
- tag aliasing within one slot;
- same-cycle read-before-write;
- mispredict values measured against a reference table.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    HIST_SNT = 2'b00,
    HIST_WNT = 2'b01,
    HIST_WT  = 2'b10,
    HIST_ST  = 2'b11
  } hist_e;
endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/btb_hist_next.sv
module btb_hist_next
  import btb_pkg::*;
(
  input  logic  hit_i,
  input  hist_e cur_i,
  input  logic  taken_i,
  output hist_e nxt_o
);
  always_comb begin
    nxt_o = HIST_SNT;
    if (hit_i) begin
      unique case (cur_i)
        HIST_SNT: nxt_o = taken_i ? HIST_WNT : HIST_SNT;
        HIST_WNT: nxt_o = taken_i ? HIST_WT  : HIST_SNT;
        HIST_WT:  nxt_o = taken_i ? HIST_ST  : HIST_WNT;
        HIST_ST:  nxt_o = taken_i ? HIST_ST  : HIST_WT;
        default:  nxt_o = HIST_SNT;
      endcase
    end
  end
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128,
  parameter int NRD     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc_i   [NRD],
  output logic              rd_hit_o  [NRD],
  output hist_e             rd_hist_o [NRD],
  output logic [ADDR_W-1:0] rd_tgt_o  [NRD],
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  hist_e             wr_hist_i,
  output logic [ENTRIES-1:0] valid_o
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TAG_LSB = IDX_W + 2;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];
  hist_e              hist_q [ENTRIES];

  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;

  assign wr_idx = wr_pc_i[TAG_LSB-1:2];
  assign wr_tag = wr_pc_i[ADDR_W-1:TAG_LSB];

  // next state of the valid bits
  always_comb begin
    valid_d = valid_q;
    if (wr_en_i) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // payload fields carry no reset; valid bits qualify them
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx]  <= wr_tag;
      tgt_q[wr_idx]  <= wr_tgt_i;
      hist_q[wr_idx] <= wr_hist_i;
    end
  end

  generate
    for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
      logic [IDX_W-1:0] idx;
      assign idx           = rd_pc_i[gp][TAG_LSB-1:2];
      assign rd_hit_o[gp]  = valid_q[idx] && (tag_q[idx] == rd_pc_i[gp][ADDR_W-1:TAG_LSB]);
      assign rd_hist_o[gp] = hist_q[idx];
      assign rd_tgt_o[gp]  = tgt_q[idx];
    end
  endgenerate

  assign valid_o = valid_q;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              pred_hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  output logic              mispredict_o
);
  localparam int NRD     = 2;
  localparam int RD_LOOK = 0;
  localparam int RD_UPD  = 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic rst_sn;

  logic [ADDR_W-1:0] rd_pc   [NRD];
  logic              rd_hit  [NRD];
  hist_e             rd_hist [NRD];
  logic [ADDR_W-1:0] rd_tgt  [NRD];

  logic               upd_hit;
  hist_e              upd_hist;
  logic [ADDR_W-1:0]  upd_tgt;
  logic               upd_pred_tk;
  hist_e              hist_nxt;
  logic               wr_en;
  hist_e              wr_hist;
  logic [ADDR_W-1:0]  wr_tgt;
  logic [ENTRIES-1:0] valid_vec;

  btb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign rd_pc[RD_LOOK] = fetch_pc_i;
  assign rd_pc[RD_UPD]  = upd_pc_i;

  btb_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rd_pc_i   (rd_pc),
    .rd_hit_o  (rd_hit),
    .rd_hist_o (rd_hist),
    .rd_tgt_o  (rd_tgt),
    .wr_en_i   (wr_en),
    .wr_pc_i   (upd_pc_i),
    .wr_tgt_i  (wr_tgt),
    .wr_hist_i (wr_hist),
    .valid_o   (valid_vec)
  );

  // lookup path
  always_comb begin
    pred_hit_o   = rd_hit[RD_LOOK];
    pred_taken_o = en_i && rd_hit[RD_LOOK] && rd_hist[RD_LOOK][1];
    pred_pc_o    = pred_taken_o ? rd_tgt[RD_LOOK] : fetch_pc_i + STEP;
  end

  // update path
  assign upd_hit  = rd_hit[RD_UPD];
  assign upd_hist = rd_hist[RD_UPD];
  assign upd_tgt  = rd_tgt[RD_UPD];

  btb_hist_next u_hist (
    .hit_i   (upd_hit),
    .cur_i   (upd_hist),
    .taken_i (upd_taken_i),
    .nxt_o   (hist_nxt)
  );

  always_comb begin
    upd_pred_tk  = en_i && upd_hit && upd_hist[1];
    wr_en        = upd_valid_i && (upd_hit || upd_taken_i);
    wr_hist      = hist_nxt;
    wr_tgt       = upd_taken_i ? upd_target_i : upd_tgt;
    mispredict_o = upd_valid_i &&
                   ((upd_pred_tk != upd_taken_i) ||
                    (upd_pred_tk && upd_taken_i && (upd_tgt != upd_target_i)));
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               en_i,
  input logic [ADDR_W-1:0]  fetch_pc_i,
  input logic               pred_hit_o,
  input logic               pred_taken_o,
  input logic [ADDR_W-1:0]  pred_pc_o,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic [ADDR_W-1:0]  upd_target_i,
  input logic               mispredict_o,
  input logic               upd_hit,
  input hist_e              upd_hist,
  input logic               wr_en,
  input hist_e              wr_hist,
  input logic [ADDR_W-1:0]  wr_tgt,
  input logic [ENTRIES-1:0] valid_vec
);
  // R7
  taken_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pred_taken_o |-> (en_i && pred_hit_o));

  // R3
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !pred_taken_o |-> (pred_pc_o == fetch_pc_i + ADDR_W'(4)));

  // R4
  alloc_snt_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (upd_valid_i && upd_taken_i && !upd_hit) |->
      (wr_en && wr_hist == HIST_SNT && wr_tgt == upd_target_i));

  // R5
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (upd_valid_i && !upd_taken_i && !upd_hit) |=> $stable(valid_vec));

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (upd_valid_i && upd_hit && upd_taken_i && upd_hist == HIST_ST) |-> (wr_hist == HIST_ST));

  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (upd_valid_i && upd_hit && !upd_taken_i && upd_hist == HIST_SNT) |-> (wr_hist == HIST_SNT));

  // R8
  mis_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !upd_valid_i |-> !mispredict_o);

  // R8
  mis_miss_nt_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (upd_valid_i && !upd_hit && !upd_taken_i) |-> !mispredict_o);
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .en_i         (en_i),
  .fetch_pc_i   (fetch_pc_i),
  .pred_hit_o   (pred_hit_o),
  .pred_taken_o (pred_taken_o),
  .pred_pc_o    (pred_pc_o),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i),
  .upd_target_i (upd_target_i),
  .mispredict_o (mispredict_o),
  .upd_hit      (upd_hit),
  .upd_hist     (upd_hist),
  .wr_en        (wr_en),
  .wr_hist      (wr_hist),
  .wr_tgt       (wr_tgt),
  .valid_vec    (valid_vec)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [31:0] fetch_pc_i;
  logic        pred_hit_o, pred_taken_o;
  logic [31:0] pred_pc_o;
  logic        upd_valid_i, upd_taken_i;
  logic [31:0] upd_pc_i, upd_target_i;
  logic        mispredict_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference table
  bit          m_valid [N];
  logic [22:0] m_tag   [N];
  logic [31:0] m_tgt   [N];
  logic [1:0]  m_hist  [N];

  always #2.5 clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .fetch_pc_i(fetch_pc_i),
    .pred_hit_o(pred_hit_o), .pred_taken_o(pred_taken_o), .pred_pc_o(pred_pc_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
    .upd_target_i(upd_target_i), .mispredict_o(mispredict_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [31:0] pc);
    return m_valid[pc[8:2]] && (m_tag[pc[8:2]] == pc[31:9]);
  endfunction

  function automatic logic [33:0] m_pred(input logic [31:0] pc, input bit en);
    bit h, t;
    h = m_hit(pc);
    t = en && h && m_hist[pc[8:2]][1];
    return {h, t, (t ? m_tgt[pc[8:2]] : pc + 32'd4)};
  endfunction

  function automatic bit m_mis(input logic [31:0] pc, input logic [31:0] tg, input bit tk, input bit en);
    bit pt;
    pt = en && m_hit(pc) && m_hist[pc[8:2]][1];
    return (pt != tk) || (pt && tk && m_tgt[pc[8:2]] != tg);
  endfunction

  task automatic m_apply(input logic [31:0] pc, input logic [31:0] tg, input bit tk);
    int i;
    i = int'(pc[8:2]);
    if (m_hit(pc)) begin
      if (tk) begin
        if (m_hist[i] != 2'b11) m_hist[i] = m_hist[i] + 2'd1;
        m_tgt[i] = tg;
      end else if (m_hist[i] != 2'b00) m_hist[i] = m_hist[i] - 2'd1;
    end else if (tk) begin
      m_valid[i] = 1; m_tag[i] = pc[31:9]; m_tgt[i] = tg; m_hist[i] = 2'b00;
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    logic [33:0] e;
    @(negedge clk);
    fetch_pc_i = pc;
    #1;
    e = m_pred(pc, en_i);
    check({pred_hit_o, pred_taken_o, pred_pc_o} == e, req,
          {30'd0, pred_hit_o, pred_taken_o, pred_pc_o}, {30'd0, e});
  endtask

  // update with a same-cycle lookup of the same address (R9: old contents visible)
  task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input bit tk, input string req);
    logic [33:0] e;
    bit em;
    @(negedge clk);
    upd_valid_i = 1; upd_pc_i = pc; upd_target_i = tg; upd_taken_i = tk;
    fetch_pc_i = pc;
    #1;
    em = m_mis(pc, tg, tk, en_i);
    check(mispredict_o == em, {req, " R8 mispredict"}, 64'(mispredict_o), 64'(em));
    e = m_pred(pc, en_i);
    check({pred_hit_o, pred_taken_o, pred_pc_o} == e, "R9 same-cycle lookup",
          {30'd0, pred_hit_o, pred_taken_o, pred_pc_o}, {30'd0, e});
    @(posedge clk);
    m_apply(pc, tg, tk);
    #1;
    upd_valid_i = 0;
  endtask

  function automatic logic [31:0] base_pc(input int i);
    return 32'h0000_1000 + 32'(i) * 32'd4;
  endfunction

  function automatic logic [31:0] base_tg(input int i);
    return 32'h8000_0000 ^ (32'(i) << 6);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en_i = 1; fetch_pc_i = '0;
    upd_valid_i = 0; upd_pc_i = '0; upd_taken_i = 0; upd_target_i = '0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_hist[i] = 2'b00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: empty after reset
    for (int i = 0; i < N; i++) look(base_pc(i), "R1 reset miss");
    check(mispredict_o == 1'b0, "R8 idle", 64'(mispredict_o), 64'd0);

    // R4: allocate every slot on a first taken outcome, starting strongly not-taken
    for (int i = 0; i < N; i++) begin
      upd(base_pc(i), base_tg(i), 1'b1, "R4 alloc");
      look(base_pc(i), "R4 new entry sequential");
    end

    // R5: a not-taken miss leaves the slot and its resident alone
    for (int i = 0; i < 8; i++) begin
      upd(base_pc(i) + 32'h400, 32'h1234_5670, 1'b0, "R5 nt miss");
      look(base_pc(i) + 32'h400, "R5 still miss");
      look(base_pc(i), "R5 resident kept");
    end

    // R2, R3, R6: walk the counter of slot 5 up and down
    upd(base_pc(5), base_tg(5), 1'b1, "R6 step");  look(base_pc(5), "R3 weak not-taken");
    upd(base_pc(5), base_tg(5), 1'b1, "R6 step");  look(base_pc(5), "R2 weak taken");
    upd(base_pc(5), base_tg(5), 1'b1, "R6 step");  look(base_pc(5), "R2 strong taken");
    upd(base_pc(5), base_tg(5), 1'b1, "R6 sat");   look(base_pc(5), "R6 saturate high");
    upd(base_pc(5), base_tg(5), 1'b0, "R6 down");  look(base_pc(5), "R6 one step down");
    upd(base_pc(5), base_tg(5), 1'b0, "R6 down");  look(base_pc(5), "R3 back to not-taken");
    upd(base_pc(5), base_tg(5), 1'b0, "R6 down");  look(base_pc(5), "R6 strong not-taken");
    upd(base_pc(5), base_tg(5), 1'b0, "R6 sat");   look(base_pc(5), "R6 saturate low");

    // R6: target replaced on a taken hit
    upd(base_pc(9), base_tg(9), 1'b1, "R6 train");
    upd(base_pc(9), base_tg(9), 1'b1, "R6 train");
    upd(base_pc(9), 32'h0BAD_0F00, 1'b1, "R6 new target");
    look(base_pc(9), "R6 target replaced");

    // R10: alias with same index, other tag
    look(base_pc(9) + 32'h200, "R10 alias miss");
    upd(base_pc(9) + 32'h200, 32'h0000_7700, 1'b1, "R10 alias alloc");
    look(base_pc(9), "R10 old tag evicted");
    look(base_pc(9) + 32'h200, "R10 alias hit");

    // R7: disabled prediction, training continues
    upd(base_pc(20), base_tg(20), 1'b1, "R7 train");
    upd(base_pc(20), base_tg(20), 1'b1, "R7 train");
    en_i = 0;
    look(base_pc(20), "R7 disabled sequential");
    upd(base_pc(20), base_tg(20), 1'b1, "R7 disabled update");
    en_i = 1;
    look(base_pc(20), "R7 trained while disabled");

    // mixed sweep against the reference table
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] pc, pc2, tg;
      pc  = 32'h0001_0000 + 32'($urandom_range(0, 2)) * 32'h200 + 32'($urandom_range(0, N-1)) * 32'd4;
      pc2 = 32'h0001_0000 + 32'($urandom_range(0, 2)) * 32'h200 + 32'($urandom_range(0, N-1)) * 32'd4;
      tg  = {$urandom_range(0, 3), 2'b00} << 8;
      en_i = ($urandom_range(0, 7) != 0);
      upd(pc, tg, 1'($urandom_range(0, 2) != 0), "R6 mixed");
      look(pc2, "R2 R3 mixed lookup");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule